// File: doc/BRIEF.md
# System Address Decoder with Banked Work RAM

This block sits between a CPU's 16-bit address bus and the memories and peripherals of a small system. On every bus cycle it raises exactly one select line for the region the address falls in, together with the offset of the address inside that region. The regions are boot ROM, cartridge, video RAM, object attribute memory, work RAM, the I/O peripherals, high RAM and interrupt enable. Each target then decodes only its own offset.

The block holds two small registers of its own. The boot-disable register controls a boot ROM that overlays the lowest addresses after reset. The work-RAM bank register picks which 4 KB bank appears in the upper half of the work-RAM window. The translated work-RAM address is produced here, so the work RAM itself sees one flat array. Reads of the two held registers return their contents on `rd_data`. Reads of unmapped addresses return all ones.

The select and address outputs are combinational from the bus inputs and the two registers. The registers update on the rising clock edge of a write cycle. When `wr_en` and `rd_en` are both high, the cycle is decoded as a write.

Top module: `sys_addr_decoder`

## Requirements
- R1: While the boot-disable register is zero, a read from 0x0000–0x0100 raises select bit 0 (boot ROM) with offset equal to the address. A read in that range when the register is non-zero, and any write in that range, raises select bit 1 (cartridge) instead.
- R2: Addresses 0x0101–0x7FFF and 0xA000–0xBFFF raise select bit 1 (cartridge) for reads and writes, with offset equal to the unchanged address.
- R3: 0x8000–0x9FFF raises bit 2 (video RAM) with offset addr−0x8000. 0xFE00–0xFE9F raises bit 3 (object attribute memory) with offset addr−0xFE00.
- R4: 0xC000–0xCFFF and its mirror 0xE000–0xEFFF raise bit 4 (work RAM) with offset addr[11:0] and a work-RAM address of addr[11:0] (bank 0).
- R5: 0xD000–0xDFFF raises bit 4 with work-RAM address bank×0x1000 + addr[11:0]. The bank is the stored bank register, and a stored 0 is used as bank 1.
- R6: The peripheral selects are: bit 5 serial (0xFF01–0xFF02), bit 6 timer (0xFF04–0xFF07), bit 7 interrupt flags (0xFF0F), bit 8 sound (0xFF10–0xFF26 and 0xFF30–0xFF3F), bit 9 display (0xFF40–0xFF4B). Each has offset addr−0xFF00.
- R7: A write to 0xFF46 raises bit 10 (object DMA trigger) and not the display select. A read of 0xFF46 raises bit 9 (display).
- R8: 0xFF51–0xFF55 raise bit 12 (video DMA registers) and 0xFFFF raises bit 15 (interrupt enable), both with offset addr−0xFF00. 0xFF80–0xFFFE raises bit 14 (high RAM) with offset addr−0xFF80.
- R9: 0xFF50 raises bit 11 and 0xFF70 raises bit 13. A write to 0xFF50 stores all 8 data bits, and a write to 0xFF70 stores the low 3 bits. The stored value (zero-extended for the bank) appears on `rd_data` while the address is selected, from the cycle after the write.
- R10: Any other address raises bit 16 (unmapped) with offset 0 and `rd_data` 0xFF. Every mapped region other than bits 11 and 13 gives `rd_data` 0x00.
- R11: While `rd_en` or `wr_en` is high, exactly one select bit is set. When both are low, all select bits are zero.
- R12: After a synchronous reset, both held registers read zero, so the boot ROM is overlaid and 0xD000 maps to bank 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read cycle strobe |
| wr_en | input | 1 | Write cycle strobe |
| wr_data | input | 8 | Write data |
| sel | output | 17 | One-hot region select, bit order per R1–R10 |
| offset | output | 16 | Address offset inside the selected region |
| wram_addr | output | 15 | Translated flat work-RAM address |
| rd_data | output | 8 | Read data for held registers, 0xFF when unmapped |

## Verification
Two things can meet on the same clock edge: an update of a held register, and the decode that depends on it. A write to 0xFF50 or 0xFF70 is followed at once by a read of 0x0000 or 0xD000. The decode in that very next cycle must already reflect the new value, while the decode in the write cycle itself must still show the old state. The random phase mixes register writes with accesses to the overlay and banked ranges. Every cycle is compared against a model whose registers change only after the write's clock edge.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
// Package: shared region encoding and address landmarks for the system
// address decoder. The region index doubles as the bit position in the
// one-hot select vector.
package sad_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int NUM_REGIONS = 17;

    typedef enum logic [4:0] {
        RG_BOOT    = 5'd0,
        RG_CART    = 5'd1,
        RG_VRAM    = 5'd2,
        RG_OAM     = 5'd3,
        RG_WRAM    = 5'd4,
        RG_SERIAL  = 5'd5,
        RG_TIMER   = 5'd6,
        RG_IFLAG   = 5'd7,
        RG_SOUND   = 5'd8,
        RG_DISP    = 5'd9,
        RG_OAMDMA  = 5'd10,
        RG_BOOTCTL = 5'd11,
        RG_VDMA    = 5'd12,
        RG_WBANK   = 5'd13,
        RG_HRAM    = 5'd14,
        RG_IE      = 5'd15,
        RG_NONE    = 5'd16
    } region_e;

    localparam logic [ADDR_W-1:0] BOOT_LAST   = 16'h0100;
    localparam logic [ADDR_W-1:0] BOOTCTL_A   = 16'hFF50;
    localparam logic [ADDR_W-1:0] WBANK_A     = 16'hFF70;
    localparam logic [ADDR_W-1:0] OAMDMA_A    = 16'hFF46;
    localparam logic [ADDR_W-1:0] VRAM_BASE   = 16'h8000;
    localparam logic [ADDR_W-1:0] OAM_BASE    = 16'hFE00;
    localparam logic [ADDR_W-1:0] IO_BASE     = 16'hFF00;
    localparam logic [ADDR_W-1:0] HRAM_BASE   = 16'hFF80;

endpackage

// File: rtl/sad_region_decode.sv
`timescale 1ns/1ps
// Module: sad_region_decode
// Maps an address to one region and the offset within it. Purely
// combinational. Assumes the caller qualifies the result with a bus strobe;
// is_write steers the boot overlay and the object DMA trigger.
module sad_region_decode
    import sad_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              boot_on,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);

    // Priority chain over the address map; first match wins.
    always_comb begin
        region = RG_NONE;
        if (addr <= BOOT_LAST)
            region = (boot_on && !is_write) ? RG_BOOT : RG_CART;
        else if (addr <= 16'h7FFF)                         region = RG_CART;
        else if (addr <= 16'h9FFF)                         region = RG_VRAM;
        else if (addr <= 16'hBFFF)                         region = RG_CART;
        else if (addr <= 16'hEFFF)                         region = RG_WRAM;
        else if (addr >= 16'hFE00 && addr <= 16'hFE9F)     region = RG_OAM;
        else if (addr >= 16'hFF01 && addr <= 16'hFF02)     region = RG_SERIAL;
        else if (addr >= 16'hFF04 && addr <= 16'hFF07)     region = RG_TIMER;
        else if (addr == 16'hFF0F)                         region = RG_IFLAG;
        else if (addr >= 16'hFF10 && addr <= 16'hFF26)     region = RG_SOUND;
        else if (addr >= 16'hFF30 && addr <= 16'hFF3F)     region = RG_SOUND;
        else if (addr == OAMDMA_A && is_write)             region = RG_OAMDMA;
        else if (addr >= 16'hFF40 && addr <= 16'hFF4B)     region = RG_DISP;
        else if (addr == BOOTCTL_A)                        region = RG_BOOTCTL;
        else if (addr >= 16'hFF51 && addr <= 16'hFF55)     region = RG_VDMA;
        else if (addr == WBANK_A)                          region = RG_WBANK;
        else if (addr >= HRAM_BASE && addr <= 16'hFFFE)    region = RG_HRAM;
        else if (addr == 16'hFFFF)                         region = RG_IE;
    end

    // Offset relative to the selected region's base.
    always_comb begin
        case (region)
            RG_BOOT, RG_CART: offset = addr;
            RG_VRAM:          offset = addr - VRAM_BASE;
            RG_OAM:           offset = addr - OAM_BASE;
            RG_WRAM:          offset = {4'h0, addr[11:0]};
            RG_HRAM:          offset = addr - HRAM_BASE;
            RG_NONE:          offset = '0;
            default:          offset = addr - IO_BASE;
        endcase
    end

endmodule

// File: rtl/sad_ctrl_regs.sv
`timescale 1ns/1ps
// Module: sad_ctrl_regs
// Holds the boot-disable register and the work-RAM bank register.
// Assumes one write per cycle; writes land on the rising edge.
module sad_ctrl_regs
    import sad_pkg::*;
#(
    parameter int WBANK_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  boot_q,
    output logic [WBANK_W-1:0] bank_q
);

    // Boot-disable register: any non-zero value lifts the overlay.
    always_ff @(posedge clk) begin
        if (!rst_n)                          boot_q <= '0;
        else if (wr_en && addr == BOOTCTL_A) boot_q <= wr_data;
    end

    // Work-RAM bank register: keeps the low WBANK_W data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        bank_q <= '0;
        else if (wr_en && addr == WBANK_A) bank_q <= wr_data[WBANK_W-1:0];
    end

endmodule

// File: rtl/sad_wram_map.sv
`timescale 1ns/1ps
// Module: sad_wram_map
// Translates a work-RAM window address into a flat array address. The lower
// 4 KB window and its mirror use bank 0; the upper window uses the bank
// register, with 0 promoted to 1.
module sad_wram_map
    import sad_pkg::*;
#(
    parameter int WBANK_W = 3,
    localparam int WRAM_AW = 12 + WBANK_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WBANK_W-1:0] bank_q,
    output logic [WRAM_AW-1:0] wram_addr
);

    logic [WBANK_W-1:0] eff_bank;

    // Bank 0 is not addressable in the switched window.
    always_comb eff_bank = (bank_q == '0) ? WBANK_W'(1) : bank_q;

    // Pick the bank by window and splice the in-bank offset.
    always_comb begin
        if (addr[15:12] == 4'hD) wram_addr = {eff_bank, addr[11:0]};
        else                     wram_addr = {{WBANK_W{1'b0}}, addr[11:0]};
    end

endmodule

// File: rtl/sys_addr_decoder.sv
`timescale 1ns/1ps
// Module: sys_addr_decoder (top)
// Decodes a CPU bus cycle into a one-hot region select, an in-region offset,
// a flat work-RAM address and read data for the two held registers.
// Assumes rd_en/wr_en mark a valid cycle; a cycle with both is a write.
module sys_addr_decoder
    import sad_pkg::*;
#(
    parameter int WBANK_W = 3,
    localparam int WRAM_AW = 12 + WBANK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [NUM_REGIONS-1:0] sel,
    output logic [ADDR_W-1:0]      offset,
    output logic [WRAM_AW-1:0]     wram_addr,
    output logic [DATA_W-1:0]      rd_data
);

    logic [DATA_W-1:0]  boot_q;
    logic [WBANK_W-1:0] bank_q;
    region_e            region;
    logic               access;

    sad_ctrl_regs #(.WBANK_W(WBANK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .boot_q  (boot_q),
        .bank_q  (bank_q)
    );

    sad_region_decode u_dec (
        .addr     (addr),
        .is_write (wr_en),
        .boot_on  (boot_q == '0),
        .region   (region),
        .offset   (offset)
    );

    sad_wram_map #(.WBANK_W(WBANK_W)) u_wmap (
        .addr      (addr),
        .bank_q    (bank_q),
        .wram_addr (wram_addr)
    );

    // A bus cycle is in progress.
    always_comb access = rd_en | wr_en;

    // One select line per region, gated by the bus strobe.
    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_sel
        assign sel[gi] = access && (region == region_e'(gi));
    end

    // Read data for the registers held here, all ones when unmapped.
    always_comb begin
        case (region)
            RG_BOOTCTL: rd_data = boot_q;
            RG_WBANK:   rd_data = {{(DATA_W-WBANK_W){1'b0}}, bank_q};
            RG_NONE:    rd_data = '1;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/sad_checker.sv
`timescale 1ns/1ps
// Module: sad_checker
// Temporal checks on the decoder's ports; attached by bind below.
module sad_checker
    import sad_pkg::*;
#(
    parameter int WBANK_W = 3,
    localparam int WRAM_AW = 12 + WBANK_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      addr,
    input logic                   rd_en,
    input logic                   wr_en,
    input logic [DATA_W-1:0]      wr_data,
    input logic [NUM_REGIONS-1:0] sel,
    input logic [ADDR_W-1:0]      offset,
    input logic [WRAM_AW-1:0]     wram_addr,
    input logic [DATA_W-1:0]      rd_data
);

    // R11: one select per valid cycle
    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> ($countones(sel) == 1));

    // R11: no select when idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |-> (sel == '0));

    // R1: writes into the overlay range reach the cartridge
    assert_boot_write_cart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr <= BOOT_LAST) |-> (sel[RG_CART] && !sel[RG_BOOT]));

    // R1: after a non-zero boot-disable write, overlay reads go to the cartridge
    assert_overlay_lifted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == BOOTCTL_A && wr_data != 8'h00) |=>
            (!(rd_en && !wr_en && addr <= BOOT_LAST) || sel[RG_CART]));

    // R5: the switched window never maps onto bank 0
    assert_no_bank0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[RG_WRAM] && addr[15:12] == 4'hD) |-> (wram_addr[WRAM_AW-1:12] != '0));

    // R4: fixed window and mirror use bank 0 and the low address bits
    assert_fixed_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[RG_WRAM] && addr[15:12] != 4'hD) |->
            (wram_addr == {{WBANK_W{1'b0}}, addr[11:0]} && offset[11:0] == addr[11:0]));

    // R7: DMA trigger write never shows as a display select
    assert_dma_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OAMDMA_A) |-> (sel[RG_OAMDMA] && !sel[RG_DISP]));

    // R9: boot-disable value is readable the cycle after it is written
    assert_bootctl_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == BOOTCTL_A) |=>
            (!(addr == BOOTCTL_A && !wr_en) || rd_data == $past(wr_data)));

    // R10: unmapped cycles float high
    assert_unmapped_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel[RG_NONE] |-> (rd_data == 8'hFF && offset == '0));

endmodule

bind sys_addr_decoder sad_checker #(.WBANK_W(WBANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sel       (sel),
    .offset    (offset),
    .wram_addr (wram_addr),
    .rd_data   (rd_data)
);

// File: tb/sys_addr_decoder_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random bus cycles, each
// compared with a model built from the requirements.
module sys_addr_decoder_tb;

    localparam int B_BOOT = 0, B_CART = 1, B_VRAM = 2, B_OAM = 3, B_WRAM = 4;
    localparam int B_SER = 5, B_TIM = 6, B_IF = 7, B_SND = 8, B_DISP = 9;
    localparam int B_ODMA = 10, B_BCTL = 11, B_VDMA = 12, B_WBNK = 13;
    localparam int B_HRAM = 14, B_IE = 15, B_NONE = 16;

    int checks = 0;
    int fails  = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [16:0] sel;
    logic [15:0] offset;
    logic [14:0] wram_addr;
    logic [7:0]  rd_data;

    logic [7:0]  m_boot = '0;
    logic [2:0]  m_bank = '0;

    sys_addr_decoder #(.WBANK_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .sel(sel), .offset(offset), .wram_addr(wram_addr),
        .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic int exp_region(input logic [15:0] a, input logic w, input logic [7:0] bt);
        if (a <= 16'h0100)                    return (bt == 0 && !w) ? B_BOOT : B_CART;
        if (a <= 16'h7FFF)                    return B_CART;
        if (a <= 16'h9FFF)                    return B_VRAM;
        if (a <= 16'hBFFF)                    return B_CART;
        if (a <= 16'hEFFF)                    return B_WRAM;
        if (a >= 16'hFE00 && a <= 16'hFE9F)   return B_OAM;
        if (a == 16'hFF01 || a == 16'hFF02)   return B_SER;
        if (a >= 16'hFF04 && a <= 16'hFF07)   return B_TIM;
        if (a == 16'hFF0F)                    return B_IF;
        if ((a >= 16'hFF10 && a <= 16'hFF26) || (a >= 16'hFF30 && a <= 16'hFF3F)) return B_SND;
        if (a == 16'hFF46 && w)               return B_ODMA;
        if (a >= 16'hFF40 && a <= 16'hFF4B)   return B_DISP;
        if (a == 16'hFF50)                    return B_BCTL;
        if (a >= 16'hFF51 && a <= 16'hFF55)   return B_VDMA;
        if (a == 16'hFF70)                    return B_WBNK;
        if (a >= 16'hFF80 && a <= 16'hFFFE)   return B_HRAM;
        if (a == 16'hFFFF)                    return B_IE;
        return B_NONE;
    endfunction

    function automatic logic [15:0] exp_offset(input int r, input logic [15:0] a);
        case (r)
            B_BOOT, B_CART: return a;
            B_VRAM:         return a - 16'h8000;
            B_OAM:          return a - 16'hFE00;
            B_WRAM:         return {4'h0, a[11:0]};
            B_HRAM:         return a - 16'hFF80;
            B_NONE:         return 16'h0000;
            default:        return a - 16'hFF00;
        endcase
    endfunction

    function automatic logic [14:0] exp_wram(input logic [15:0] a, input logic [2:0] bk);
        logic [2:0] eb;
        eb = (bk == 3'd0) ? 3'd1 : bk;
        return (a[15:12] == 4'hD) ? {eb, a[11:0]} : {3'd0, a[11:0]};
    endfunction

    function automatic logic [7:0] exp_rd(input int r);
        case (r)
            B_BCTL:  return m_boot;
            B_WBNK:  return {5'd0, m_bank};
            B_NONE:  return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input int r, input logic [15:0] a);
        case (r)
            B_BOOT:                   return "R1";
            B_CART:                   return (a <= 16'h0100) ? "R1" : "R2";
            B_VRAM, B_OAM:            return "R3";
            B_WRAM:                   return (a[15:12] == 4'hD) ? "R5" : "R4";
            B_SER, B_TIM, B_IF, B_SND: return "R6";
            B_DISP, B_ODMA:           return "R7";
            B_BCTL, B_WBNK:           return "R9";
            B_NONE:                   return "R10";
            default:                  return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one bus cycle, compare outputs mid-cycle, then update the model.
    task automatic cyc(input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
        int r;
        string t;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wr_data = d;
        #5;
        if (rd || wr) begin
            r = exp_region(a, wr, m_boot);
            t = (tag == "") ? req_of(r, a) : tag;
            check({t, " sel"}, 32'(sel), 32'(17'd1 << r));
            check({t, " offset"}, 32'(offset), 32'(exp_offset(r, a)));
            check({t, " rd_data"}, 32'(rd_data), 32'(exp_rd(r)));
            if (r == B_WRAM) check({t, " wram_addr"}, 32'(wram_addr), 32'(exp_wram(a, m_bank)));
        end else begin
            check("R11 idle sel", 32'(sel), 32'd0);
        end
        @(posedge clk);
        #1;
        if (wr && rst_n) begin
            if (a == 16'hFF50) m_boot = d;
            if (a == 16'hFF70) m_bank = d[2:0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        m_boot = '0; m_bank = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] a;
        int sel_kind;
        void'($urandom(32'd20240611));
        do_reset();

        // R12: reset state
        cyc(1, 0, 16'hFF50, 8'h00, "R12 bootctl");
        cyc(1, 0, 16'hFF70, 8'h00, "R12 bank");
        cyc(1, 0, 16'h0000, 8'h00, "R12 overlay");
        cyc(1, 0, 16'hD123, 8'h00, "R12 bank1");
        cyc(0, 0, 16'h0000, 8'h00, "R11");

        // R1: overlay boundary and write forwarding
        cyc(1, 0, 16'h0100, 8'h00, "R1 edge");
        cyc(1, 0, 16'h0101, 8'h00, "R2 edge");
        cyc(0, 1, 16'h0050, 8'h3C, "R1 write");

        // R5: bank register, 0 treated as 1, stored width limited
        cyc(0, 1, 16'hFF70, 8'h05, "R9 bank wr");
        cyc(1, 0, 16'hD123, 8'h00, "R5 bank5");
        cyc(0, 1, 16'hFF70, 8'hFF, "R9 bank wr");
        cyc(1, 0, 16'hFF70, 8'h00, "R9 bank rd");
        cyc(1, 0, 16'hDFFF, 8'h00, "R5 bank7");
        cyc(0, 1, 16'hFF70, 8'h00, "R9 bank wr");
        cyc(1, 0, 16'hD000, 8'h00, "R5 bank0");
        cyc(1, 0, 16'hE456, 8'h00, "R4 mirror");
        cyc(1, 0, 16'hC000, 8'h00, "R4 fixed");

        // R7 / R3 / R6 / R8 / R10 landmarks
        cyc(0, 1, 16'hFF46, 8'h80, "R7 dma wr");
        cyc(1, 0, 16'hFF46, 8'h00, "R7 dma rd");
        cyc(1, 0, 16'h9FFF, 8'h00, "R3 vram");
        cyc(1, 0, 16'hFE9F, 8'h00, "R3 oam");
        cyc(1, 0, 16'hFEA0, 8'h00, "R10 gap");
        cyc(1, 0, 16'hFF03, 8'h00, "R10 gap");
        cyc(1, 0, 16'hF000, 8'h00, "R10 gap");
        cyc(1, 0, 16'hFF26, 8'h00, "R6 sound");
        cyc(1, 0, 16'hFF0F, 8'h00, "R6 iflag");
        cyc(1, 0, 16'hFF55, 8'h00, "R8 vdma");
        cyc(1, 0, 16'hFFFE, 8'h00, "R8 hram");
        cyc(1, 0, 16'hFFFF, 8'h00, "R8 ie");
        cyc(1, 1, 16'h0000, 8'h11, "R1 both");

        // R1 / R9: lift overlay and read back immediately
        cyc(0, 1, 16'hFF50, 8'h01, "R9 boot wr");
        cyc(1, 0, 16'h0000, 8'h00, "R1 lifted");
        cyc(1, 0, 16'hFF50, 8'h00, "R9 boot rd");
        do_reset();
        cyc(1, 0, 16'h0000, 8'h00, "R12 relatch");

        // Random phase with periodic resets
        for (int i = 0; i < 6000; i++) begin
            if (i % 700 == 699) do_reset();
            sel_kind = int'($urandom % 8);
            case (sel_kind)
                0: a = 16'($urandom) & 16'h01FF;
                1: a = 16'hD000 | (16'($urandom) & 16'h0FFF);
                2: a = 16'hFF00 | (16'($urandom) & 16'h00FF);
                3: a = ($urandom % 2 == 0) ? 16'hFF50 : 16'hFF70;
                4: a = ($urandom % 4 == 0) ? 16'hFF50 : 16'h0000 | (16'($urandom) & 16'h0101);
                default: a = 16'($urandom);
            endcase
            case ($urandom % 4)
                0:       cyc(0, 0, a, 8'($urandom), "");
                1:       cyc(0, 1, a, ($urandom % 3 == 0) ? 8'h00 : 8'($urandom), "");
                default: cyc(1, 0, a, 8'h00, "");
            endcase
        end
        summary();
    end

endmodule